// File: doc/BRIEF.md
# Serial Audio Link Frame Deserializer

This block receives a serial audio link made of a bit clock, a frame marker line and one serial data line. It brings the three lines into the system clock domain and samples the marker and data lines on each falling edge of the bit clock. It finds the start of every frame and shifts the data bits in, most significant bit first. Each frame is cut into a 16-bit tag slot and twelve 20-bit data slots, 256 bits in all.

When a slot completes, the block raises `slot_valid` for one system clock. At the same time it presents the slot number and a 20-bit word that is left-aligned. For the audio slots it also presents the upper sixteen bits of the word as a sample. One instance handles one direction of the link, so a full-duplex link needs two instances. The system clock must run at least four times faster than the bit clock.

The framing state machine has three states:
- `FR_IDLE`: waiting for the first frame after reset.
- `FR_RECV`: collecting the bits of a frame.
- `FR_DONE`: the frame is full and further bits are ignored.

Its transitions are:
- start: `FR_IDLE`, `FR_RECV` or `FR_DONE` go to `FR_RECV` when a frame start is seen.
- fill: `FR_RECV` goes to `FR_DONE` when bit 256 arrives.
- hold: otherwise the state stays where it is.

Top module: `aclink_deser`

## Requirements
- R1: The marker and data lines are sampled only at falling edges of `bit_clk_i`. A data value that changes at rising edges and is stable across the falling edge is captured exactly.
- R2: A frame starts on the bit whose two preceding marker samples were 0 and then 1, in that order. That bit is frame bit 0.
- R3: A frame is cut into slot 0 of 16 bits followed by slots 1 to 12 of 20 bits each. The slots are reported in increasing index order, 0 to 12, on `slot_idx`.
- R4: Slot bits arrive most significant bit first. `slot_word` carries the 20 received bits with the first bit in bit 19. For slot 0 the 16 tag bits sit in bits 19:4 and bits 3:0 are zero.
- R5: `slot_valid` is high for exactly one system clock per completed slot.
- R6: `sample_valid` rises together with `slot_valid` only for slot indices 3 to 11. In that cycle `sample` equals `slot_word[19:4]`.
- R7: Bits received after bit 256 of a frame produce no slot, until the next frame start.
- R8: A frame start always begins a new frame at slot 0. Any partly received slot of the previous frame is discarded.
- R9: After reset, no slot is reported until the first frame start, whatever data arrives.
- R10: `short_frame` pulses for one system clock when a frame starts before the previous frame reached 256 bits. It does not pulse for the first frame after reset, nor after a complete frame.
- R11: While and just after `rst_n` is low, `slot_valid`, `sample_valid` and `short_frame` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk_i | input | 1 | Serial bit clock (asynchronous) |
| sync_i | input | 1 | Frame marker line (asynchronous) |
| sdata_i | input | 1 | Serial data line (asynchronous) |
| slot_valid | output | 1 | One-clock pulse per completed slot |
| slot_idx | output | 4 | Index of the completed slot, 0 to 12 |
| slot_word | output | 20 | Slot bits, left-aligned, first bit in bit 19 |
| sample_valid | output | 1 | One-clock pulse for audio slots 3 to 11 |
| sample | output | 16 | Upper 16 bits of the audio slot |
| short_frame | output | 1 | Pulse when a frame restarts before reaching 256 bits |

## Verification
The main function is driven through a table of frames. Full 256-bit frames with different tags and payloads show that slot boundaries and bit order are right. A 100-bit frame and a tag-only frame show that a partial slot is dropped and that the short-frame flag rises. A 300-bit frame shows that trailing bits create no slot. The payload of each slot is derived from its index, so a slip of one bit or one slot changes every word that follows. Directed runs cover the reset state and noise on the data line before any frame marker, which must produce nothing.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RECV = 2'd1,
        FR_DONE = 2'd2
    } fr_state_e;

endpackage

// File: rtl/aclink_sync.sv
module aclink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_raw,
    input  logic sync_raw,
    input  logic data_raw,
    output logic bclk_fall,
    output logic sync_s,
    output logic data_s
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw_vec;
    logic [LINES-1:0] synced;
    logic             bclk_prev;

    assign raw_vec = {data_raw, sync_raw, bclk_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], raw_vec[g]};
            end
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_prev <= 1'b0;
        end else begin
            bclk_prev <= synced[0];
        end
    end

    assign bclk_fall = bclk_prev & ~synced[0];
    assign sync_s    = synced[1];
    assign data_s    = synced[2];

    // R5
    fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |=> !bclk_fall);

endmodule

// File: rtl/aclink_framer.sv
module aclink_framer
    import aclink_pkg::*;
#(
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int DATA_SLOTS = 12,
    localparam int FRAME_BITS = TAG_BITS + DATA_SLOTS * SLOT_BITS,
    localparam int IDX_W      = $clog2(DATA_SLOTS + 1),
    localparam int POS_W      = $clog2(SLOT_BITS + 1),
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_fall,
    input  logic                 sync_s,
    input  logic                 data_s,
    output logic                 emit,
    output logic [IDX_W-1:0]     emit_idx,
    output logic [SLOT_BITS-1:0] emit_word,
    output logic                 restart_short
);
    fr_state_e            state, state_nx;
    logic                 mark_h1, mark_h2;
    logic [SLOT_BITS-2:0] shreg;
    logic [SLOT_BITS-1:0] shifted;
    logic [IDX_W-1:0]     slot_idx;
    logic [POS_W-1:0]     slot_pos;
    logic [POS_W-1:0]     cur_len;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 frame_start;
    logic                 slot_end;
    logic                 frame_end;

    assign frame_start = bit_fall && !mark_h2 && mark_h1;
    assign shifted     = {shreg, data_s};
    assign cur_len     = (slot_idx == '0) ? POS_W'(TAG_BITS) : POS_W'(SLOT_BITS);
    assign slot_end    = (slot_pos + POS_W'(1)) == cur_len;
    assign frame_end   = (bit_cnt + CNT_W'(1)) == CNT_W'(FRAME_BITS);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE: if (frame_start) state_nx = FR_RECV;
            FR_RECV: begin
                if (frame_start)              state_nx = FR_RECV;
                else if (bit_fall && frame_end) state_nx = FR_DONE;
            end
            FR_DONE: if (frame_start) state_nx = FR_RECV;
            default: state_nx = FR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= state_nx;
    end

    // bit and slot counters, shift register, marker history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_h1  <= 1'b0;
            mark_h2  <= 1'b0;
            shreg    <= '0;
            slot_idx <= '0;
            slot_pos <= '0;
            bit_cnt  <= '0;
        end else if (bit_fall) begin
            mark_h2 <= mark_h1;
            mark_h1 <= sync_s;
            if (frame_start) begin
                shreg    <= {{(SLOT_BITS-2){1'b0}}, data_s};
                slot_idx <= '0;
                slot_pos <= POS_W'(1);
                bit_cnt  <= CNT_W'(1);
            end else if (state == FR_RECV) begin
                shreg   <= shifted[SLOT_BITS-2:0];
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (slot_end) begin
                    slot_pos <= '0;
                    slot_idx <= slot_idx + IDX_W'(1);
                end else begin
                    slot_pos <= slot_pos + POS_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        emit          = 1'b0;
        emit_idx      = slot_idx;
        emit_word     = shifted;
        restart_short = 1'b0;
        unique case (state)
            FR_IDLE: ;
            FR_RECV: begin
                restart_short = frame_start;
                emit = bit_fall && !frame_start && slot_end;
                if (slot_idx == '0)
                    emit_word = {shifted[TAG_BITS-1:0], {(SLOT_BITS-TAG_BITS){1'b0}}};
            end
            FR_DONE: ;
            default: ;
        endcase
    end

    // R7
    recv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_RECV) |-> (bit_cnt != '0 && bit_cnt < CNT_W'(FRAME_BITS)));

    // R3
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_RECV) |-> (slot_idx <= IDX_W'(DATA_SLOTS)));

    // R9
    idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE) |-> (bit_cnt == '0));

endmodule

// File: rtl/aclink_slot_out.sv
module aclink_slot_out #(
    parameter int SLOT_BITS   = 20,
    parameter int SAMPLE_BITS = 16,
    parameter int IDX_W       = 4,
    parameter int FIRST_AUDIO = 3,
    parameter int LAST_AUDIO  = 11,
    parameter int LAST_SLOT   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   emit,
    input  logic [IDX_W-1:0]       emit_idx,
    input  logic [SLOT_BITS-1:0]   emit_word,
    input  logic                   restart_short,
    output logic                   slot_valid,
    output logic [IDX_W-1:0]       slot_idx,
    output logic [SLOT_BITS-1:0]   slot_word,
    output logic                   sample_valid,
    output logic [SAMPLE_BITS-1:0] sample,
    output logic                   short_frame
);
    logic is_audio;

    assign is_audio = (emit_idx >= IDX_W'(FIRST_AUDIO)) && (emit_idx <= IDX_W'(LAST_AUDIO));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid   <= 1'b0;
            slot_idx     <= '0;
            slot_word    <= '0;
            sample_valid <= 1'b0;
            sample       <= '0;
            short_frame  <= 1'b0;
        end else begin
            slot_valid   <= emit;
            sample_valid <= emit && is_audio;
            short_frame  <= restart_short;
            if (emit) begin
                slot_idx  <= emit_idx;
                slot_word <= emit_word;
                if (is_audio) sample <= emit_word[SLOT_BITS-1 -: SAMPLE_BITS];
            end
        end
    end

    // R5
    slot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |=> !slot_valid);

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (slot_idx <= IDX_W'(LAST_SLOT)));

    // R6
    sample_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (slot_valid && sample == slot_word[SLOT_BITS-1 -: SAMPLE_BITS]));

    // R10
    short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_frame |=> !short_frame);

endmodule

// File: rtl/aclink_deser.sv
module aclink_deser #(
    parameter int TAG_BITS    = 16,
    parameter int SLOT_BITS   = 20,
    parameter int DATA_SLOTS  = 12,
    parameter int SAMPLE_BITS = 16,
    parameter int FIRST_AUDIO = 3,
    parameter int LAST_AUDIO  = 11,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(DATA_SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_clk_i,
    input  logic                   sync_i,
    input  logic                   sdata_i,
    output logic                   slot_valid,
    output logic [IDX_W-1:0]       slot_idx,
    output logic [SLOT_BITS-1:0]   slot_word,
    output logic                   sample_valid,
    output logic [SAMPLE_BITS-1:0] sample,
    output logic                   short_frame
);
    logic                 bit_fall, sync_s, data_s;
    logic                 emit, restart_short;
    logic [IDX_W-1:0]     emit_idx;
    logic [SLOT_BITS-1:0] emit_word;

    aclink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_raw  (bit_clk_i),
        .sync_raw  (sync_i),
        .data_raw  (sdata_i),
        .bclk_fall (bit_fall),
        .sync_s    (sync_s),
        .data_s    (data_s)
    );

    aclink_framer #(
        .TAG_BITS   (TAG_BITS),
        .SLOT_BITS  (SLOT_BITS),
        .DATA_SLOTS (DATA_SLOTS)
    ) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_fall      (bit_fall),
        .sync_s        (sync_s),
        .data_s        (data_s),
        .emit          (emit),
        .emit_idx      (emit_idx),
        .emit_word     (emit_word),
        .restart_short (restart_short)
    );

    aclink_slot_out #(
        .SLOT_BITS   (SLOT_BITS),
        .SAMPLE_BITS (SAMPLE_BITS),
        .IDX_W       (IDX_W),
        .FIRST_AUDIO (FIRST_AUDIO),
        .LAST_AUDIO  (LAST_AUDIO),
        .LAST_SLOT   (DATA_SLOTS)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .emit          (emit),
        .emit_idx      (emit_idx),
        .emit_word     (emit_word),
        .restart_short (restart_short),
        .slot_valid    (slot_valid),
        .slot_idx      (slot_idx),
        .slot_word     (slot_word),
        .sample_valid  (sample_valid),
        .sample        (sample),
        .short_frame   (short_frame)
    );

endmodule

// File: tb/aclink_deser_bench.sv
`timescale 1ns/1ps
module aclink_deser_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk_i = 1'b0;
    logic        sync_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        slot_valid;
    logic [3:0]  slot_idx;
    logic [19:0] slot_word;
    logic        sample_valid;
    logic [15:0] sample;
    logic        short_frame;

    always #2.5 clk = ~clk;

    aclink_deser u_aclink_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_clk_i    (bit_clk_i),
        .sync_i       (sync_i),
        .sdata_i      (sdata_i),
        .slot_valid   (slot_valid),
        .slot_idx     (slot_idx),
        .slot_word    (slot_word),
        .sample_valid (sample_valid),
        .sample       (sample),
        .short_frame  (short_frame)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // fields: tag[45:30] base[29:10] bit count[9:0]
    localparam int NVEC = 6;
    localparam logic [45:0] VEC [NVEC] = '{
        {16'hF800, 20'h12345, 10'd256},
        {16'h9C01, 20'hFEDCB, 10'd256},
        {16'h8001, 20'h0000F, 10'd100},
        {16'hE000, 20'hA5A5A, 10'd300},
        {16'hFFFF, 20'h80001, 10'd16},
        {16'h0000, 20'h55555, 10'd256}
    };

    // capture of output events
    logic [3:0]  cap_idx  [256];
    logic [19:0] cap_word [256];
    logic        cap_sv   [256];
    logic [15:0] cap_smp  [256];
    int cap_n = 0, short_n = 0, dbl_n = 0, orphan_n = 0;
    logic prev_sv = 1'b0;

    always @(negedge clk) begin
        if (slot_valid && cap_n < 256) begin
            cap_idx[cap_n]  = slot_idx;
            cap_word[cap_n] = slot_word;
            cap_sv[cap_n]   = sample_valid;
            cap_smp[cap_n]  = sample;
            cap_n++;
        end
        if (sample_valid && !slot_valid) orphan_n++;
        if (slot_valid && prev_sv) dbl_n++;
        if (short_frame) short_n++;
        prev_sv = slot_valid;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_word(input logic [15:0] tag, input logic [19:0] base, input int k);
        if (k == 0) return {tag, 4'h0};
        return base ^ (20'(k) * 20'h0A5C3);
    endfunction

    function automatic logic frame_bit(input logic [15:0] tag, input logic [19:0] base, input int n);
        logic [19:0] w;
        if (n < 16) return tag[15-n];
        if (n >= 256) return n[0];
        w = exp_word(tag, base, (n - 16) / 20 + 1);
        return w[19 - ((n - 16) % 20)];
    endfunction

    function automatic int exp_slots(input int nb);
        int m;
        m = (nb > 256) ? 256 : nb;
        if (m < 16) return 0;
        return 1 + (m - 16) / 20;
    endfunction

    // data changes while bit clock is high, sampled at its falling edge (R1)
    task automatic send_bit(input logic s, input logic d);
        @(negedge clk);
        sync_i = s; sdata_i = d; bit_clk_i = 1'b1;
        repeat (4) @(negedge clk);
        bit_clk_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        chk(!slot_valid && !sample_valid && !short_frame, req,
            {29'd0, slot_valid, sample_valid, short_frame}, 32'd0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base_n;
        int prev_short;
        repeat (5) @(negedge clk);
        // R11: reset state
        check_idle("R11 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R11 after reset");

        // R9: noise with marker low produces nothing
        for (int i = 0; i < 40; i++) send_bit(1'b0, i[0] ^ i[2]);
        repeat (8) @(negedge clk);
        chk(cap_n == 0, "R9 no slot before frame", cap_n, 0);

        prev_short = 0;
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] tag;
            logic [19:0] base;
            int nb, ns;
            tag  = VEC[v][45:30];
            base = VEC[v][29:10];
            nb   = int'(VEC[v][9:0]);
            base_n = cap_n;
            // R2: marker 0 then 1 before frame bit 0
            send_bit(1'b0, 1'b1);
            send_bit(1'b1, 1'b0);
            for (int n = 0; n < nb; n++)
                send_bit(n < 15, frame_bit(tag, base, n));
            repeat (8) @(negedge clk);
            ns = exp_slots(nb);
            // R3 R7 R8: slot count per frame
            chk(cap_n - base_n == ns, "R3/R7 slot count", cap_n - base_n, ns);
            for (int j = 0; j < ns && base_n + j < cap_n; j++) begin
                logic [19:0] ew;
                bit au;
                ew = exp_word(tag, base, j);
                au = (j >= 3) && (j <= 11);
                chk(cap_idx[base_n + j] == 4'(j), "R3 slot index", cap_idx[base_n + j], j);
                // R4 R1 R8: word contents
                chk(cap_word[base_n + j] == ew, "R4 slot word", cap_word[base_n + j], ew);
                // R6: sample for audio slots only
                chk(cap_sv[base_n + j] == au, "R6 sample_valid", cap_sv[base_n + j], au);
                if (au) chk(cap_smp[base_n + j] == ew[19:4], "R6 sample", cap_smp[base_n + j], ew[19:4]);
            end
            // R10: flag counts short frames before this one
            chk(short_n == prev_short, "R10 short_frame count", short_n, prev_short);
            if (nb < 256) prev_short++;
        end

        // R5: single-cycle slot pulses; R6 no orphan sample
        chk(dbl_n == 0, "R5 slot_valid pulse width", dbl_n, 0);
        chk(orphan_n == 0, "R6 sample without slot", orphan_n, 0);

        // R11 R9: reset in the middle of a frame, then noise
        base_n = cap_n;
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);
        for (int n = 0; n < 10; n++) send_bit(n < 15, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R11 mid-frame reset");
        rst_n = 1'b1;
        for (int n = 0; n < 30; n++) send_bit(1'b0, 1'b1);
        repeat (8) @(negedge clk);
        chk(cap_n == base_n, "R9 nothing after reset", cap_n, base_n);
        chk(short_n == prev_short, "R10 no flag after reset", short_n, prev_short);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule